// File: doc/BRIEF.md
# Nonvolatile Store/Recall Controller

This block sequences data transfers between a working SRAM array and the nonvolatile shadow array that sits behind it. It accepts one-cycle software requests to save the SRAM contents into the shadow (a store) or to reload the SRAM from the shadow (a recall). It also takes two digitised supply flags. One is high while the supply is above the switch threshold. The other is high while the supply is below the reset threshold. A host-write pulse marks the SRAM as modified.

A store runs as an erase phase followed by a program phase. A recall runs as a clear phase followed by a copy phase. Each phase is held on its own output line for a number of clock cycles set by a parameter, so an array model can carry out the transfer. While an operation runs, a lockout output blocks host access and an output-disable line turns off the data drivers.

When the supply drops below the switch level and the SRAM holds unsaved writes, a store starts on its own. A short completion window comes first so that a host cycle already in progress can finish. When the supply goes below the reset level, a recall is latched. That recall runs once the supply is back above the switch level.

Top module: `nv_xfer_ctrl`

## Requirements
- R1: After reset the controller is idle: `busy`, `out_dis` and all four phase outputs are low. A power-up recall is pending, and it starts as soon as `vcc_above_sw` is high.
- R2: A store drives `st_erase` high for exactly ERASE_CYC cycles, then `st_prog` high for exactly PROG_CYC cycles, and then returns to idle. At most one phase output is high in any cycle.
- R3: A software recall drives `rc_clear` high for exactly CLEAR_CYC cycles, then `rc_copy` high for exactly COPY_CYC cycles. The shadow contents are left unchanged.
- R4: A software store request is accepted while idle with `vcc_above_sw` high, whether or not any host write has happened.
- R5: A software store request is ignored while `vcc_above_sw` is low.
- R6: When idle with `vcc_above_sw` low and unsaved writes present, the controller first holds `busy` high with `out_dis` low for GRACE_CYC cycles, then runs a store. With no unsaved writes, nothing starts.
- R7: The modified flag is cleared when a store or recall ends. Host writes made while `busy` is high do not set it.
- R8: A cycle with `vcc_below_rst` high latches a recall. When `vcc_above_sw` is next high, that recall runs with `rc_clear` for CLEAR_CYC cycles and `rc_copy` for PU_COPY_CYC cycles.
- R9: A supply dip below the switch level that never reaches the reset level causes no recall on recovery.
- R10: A pending power-up recall wins over a software request that arrives in the same cycle. Requests that arrive while `busy` is high are dropped.
- R11: `out_dis` is high exactly during the four transfer phases, so it is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_store_req | input | 1 | One-cycle software store request |
| sw_recall_req | input | 1 | One-cycle software recall request |
| vcc_above_sw | input | 1 | Supply is above the switch threshold |
| vcc_below_rst | input | 1 | Supply is below the reset threshold |
| host_wr | input | 1 | Host wrote the SRAM this cycle |
| st_erase | output | 1 | Store phase 1: erase the shadow |
| st_prog | output | 1 | Store phase 2: program the shadow from the SRAM |
| rc_clear | output | 1 | Recall phase 1: clear the SRAM |
| rc_copy | output | 1 | Recall phase 2: copy the shadow into the SRAM |
| busy | output | 1 | Host access lockout |
| out_dis | output | 1 | Data output drivers disabled |

## Verification
The bench drops the supply once with unsaved writes and once with a clean array. A design that ignored the modified flag would wear the shadow with an extra store in the clean case. A design that skipped the completion window would cut off the host cycle in the dirty case. Host writes are also made during a store. A controller that counted those writes would then start a spurious store on the next supply drop.

The bench sends a software store while the supply is low, where a missing inhibit shows up as an erase phase. It brings the supply back both after a shallow dip and after a deep one. A design that recalls after the shallow dip would throw away SRAM contents, and one that misses the latched recall would leave stale data. A software store is raised in the same cycle that a latched recall becomes eligible. If priority is wrong, an erase runs ahead of the recall.

// File: rtl/nvx_pkg.sv
package nvx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GRACE,
        S_ERASE,
        S_PROG,
        S_CLEAR,
        S_COPY
    } nvx_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PU_RECALL,
        OP_AUTO_STORE,
        OP_SW_STORE,
        OP_SW_RECALL
    } nvx_op_e;

endpackage

// File: rtl/nvx_req_arb.sv
module nvx_req_arb
    import nvx_pkg::*;
(
    input  logic    pu_pend,
    input  logic    vcc_ok,
    input  logic    dirty,
    input  logic    sw_store,
    input  logic    sw_recall,
    output nvx_op_e op
);
    // Priority: latched power-up recall, then the automatic store on power
    // loss, then software store (needs a healthy supply), then software recall.
    always_comb begin
        op = OP_NONE;
        if (pu_pend && vcc_ok) begin
            op = OP_PU_RECALL;
        end else if (!vcc_ok && dirty) begin
            op = OP_AUTO_STORE;
        end else if (sw_store && vcc_ok) begin
            op = OP_SW_STORE;
        end else if (sw_recall) begin
            op = OP_SW_RECALL;
        end
    end
endmodule

// File: rtl/nvx_seq.sv
module nvx_seq
    import nvx_pkg::*;
#(
    parameter int GRACE_CYC   = 2,
    parameter int ERASE_CYC   = 4,
    parameter int PROG_CYC    = 6,
    parameter int CLEAR_CYC   = 3,
    parameter int COPY_CYC    = 5,
    parameter int PU_COPY_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  nvx_op_e    op,
    input  logic       vcc_below_rst,
    input  logic       host_wr,
    output nvx_state_e state,
    output logic       pu_pend,
    output logic       dirty
);
    localparam int MAX_A  = (GRACE_CYC > ERASE_CYC) ? GRACE_CYC : ERASE_CYC;
    localparam int MAX_B  = (PROG_CYC > CLEAR_CYC) ? PROG_CYC : CLEAR_CYC;
    localparam int MAX_C  = (COPY_CYC > PU_COPY_CYC) ? COPY_CYC : PU_COPY_CYC;
    localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_CY = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
    localparam int CNT_W  = (MAX_CY > 1) ? $clog2(MAX_CY) : 1;

    typedef struct packed {
        nvx_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             dirty;
        logic             pu_pend;
        logic             pu_run;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            S_IDLE: begin
                if (host_wr) seq_d.dirty = 1'b1;
                unique case (op)
                    OP_PU_RECALL: begin
                        seq_d.state   = S_CLEAR;
                        seq_d.cnt     = CNT_W'(CLEAR_CYC - 1);
                        seq_d.pu_run  = 1'b1;
                        seq_d.pu_pend = 1'b0;
                    end
                    OP_AUTO_STORE: begin
                        seq_d.state = S_GRACE;
                        seq_d.cnt   = CNT_W'(GRACE_CYC - 1);
                    end
                    OP_SW_STORE: begin
                        seq_d.state = S_ERASE;
                        seq_d.cnt   = CNT_W'(ERASE_CYC - 1);
                    end
                    OP_SW_RECALL: begin
                        seq_d.state  = S_CLEAR;
                        seq_d.cnt    = CNT_W'(CLEAR_CYC - 1);
                        seq_d.pu_run = 1'b0;
                    end
                    default: ;
                endcase
            end
            S_GRACE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = S_ERASE;
                    seq_d.cnt   = CNT_W'(ERASE_CYC - 1);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            S_ERASE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = S_PROG;
                    seq_d.cnt   = CNT_W'(PROG_CYC - 1);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            S_CLEAR: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = S_COPY;
                    seq_d.cnt   = seq_q.pu_run ? CNT_W'(PU_COPY_CYC - 1)
                                               : CNT_W'(COPY_CYC - 1);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            S_PROG, S_COPY: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state  = S_IDLE;
                    seq_d.dirty  = 1'b0;
                    seq_d.pu_run = 1'b0;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: seq_d.state = S_IDLE;
        endcase
        if (vcc_below_rst) seq_d.pu_pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: S_IDLE, cnt: '0, dirty: 1'b0,
                       pu_pend: 1'b1, pu_run: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state   = seq_q.state;
    assign pu_pend = seq_q.pu_pend;
    assign dirty   = seq_q.dirty;
endmodule

// File: rtl/nv_xfer_ctrl.sv
module nv_xfer_ctrl
    import nvx_pkg::*;
#(
    parameter int GRACE_CYC   = 2,
    parameter int ERASE_CYC   = 4,
    parameter int PROG_CYC    = 6,
    parameter int CLEAR_CYC   = 3,
    parameter int COPY_CYC    = 5,
    parameter int PU_COPY_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_store_req,
    input  logic sw_recall_req,
    input  logic vcc_above_sw,
    input  logic vcc_below_rst,
    input  logic host_wr,
    output logic st_erase,
    output logic st_prog,
    output logic rc_clear,
    output logic rc_copy,
    output logic busy,
    output logic out_dis
);
    nvx_op_e    op;
    nvx_state_e state;
    logic       pu_pend;
    logic       dirty;

    nvx_req_arb u_arb (
        .pu_pend   (pu_pend),
        .vcc_ok    (vcc_above_sw),
        .dirty     (dirty),
        .sw_store  (sw_store_req),
        .sw_recall (sw_recall_req),
        .op        (op)
    );

    nvx_seq #(
        .GRACE_CYC   (GRACE_CYC),
        .ERASE_CYC   (ERASE_CYC),
        .PROG_CYC    (PROG_CYC),
        .CLEAR_CYC   (CLEAR_CYC),
        .COPY_CYC    (COPY_CYC),
        .PU_COPY_CYC (PU_COPY_CYC)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .op            (op),
        .vcc_below_rst (vcc_below_rst),
        .host_wr       (host_wr),
        .state         (state),
        .pu_pend       (pu_pend),
        .dirty         (dirty)
    );

    assign st_erase = (state == S_ERASE);
    assign st_prog  = (state == S_PROG);
    assign rc_clear = (state == S_CLEAR);
    assign rc_copy  = (state == S_COPY);
    assign busy     = (state != S_IDLE);
    assign out_dis  = st_erase | st_prog | rc_clear | rc_copy;
endmodule

// File: rtl/nvx_checker.sv
module nvx_checker (
    input logic clk,
    input logic rst_n,
    input logic vcc_above_sw,
    input logic st_erase,
    input logic st_prog,
    input logic rc_clear,
    input logic rc_copy,
    input logic busy,
    input logic out_dis
);
    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_erase, st_prog, rc_clear, rc_copy})); // R2

    AST_ERASE_THEN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_erase) |-> st_prog); // R2

    AST_PROG_AFTER_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_prog) |-> $past(st_erase)); // R2

    AST_CLEAR_THEN_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rc_clear) |-> rc_copy); // R3

    AST_LOWV_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !vcc_above_sw) |=> !st_erase); // R5

    AST_ODIS_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        out_dis |-> busy); // R11
endmodule

bind nv_xfer_ctrl nvx_checker u_nvx_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .vcc_above_sw (vcc_above_sw),
    .st_erase     (st_erase),
    .st_prog      (st_prog),
    .rc_clear     (rc_clear),
    .rc_copy      (rc_copy),
    .busy         (busy),
    .out_dis      (out_dis)
);

// File: tb/nv_xfer_ctrl_bench.sv
module nv_xfer_ctrl_bench;
    localparam int GRACE_CYC   = 2;
    localparam int ERASE_CYC   = 4;
    localparam int PROG_CYC    = 6;
    localparam int CLEAR_CYC   = 3;
    localparam int COPY_CYC    = 5;
    localparam int PU_COPY_CYC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_store_req = 1'b0, sw_recall_req = 1'b0;
    logic vcc_above_sw = 1'b0, vcc_below_rst = 1'b0, host_wr = 1'b0;
    logic st_erase, st_prog, rc_clear, rc_copy, busy, out_dis;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;

    int n_checks = 0, n_fail = 0;
    int c_gr, c_er, c_pr, c_cl, c_cp, c_bad;

    logic [7:0] sram [4];
    logic [7:0] nv   [4];
    logic [7:0] snap [4];

    always #4 clk = ~clk;

    nv_xfer_ctrl #(
        .GRACE_CYC(GRACE_CYC), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC),
        .CLEAR_CYC(CLEAR_CYC), .COPY_CYC(COPY_CYC), .PU_COPY_CYC(PU_COPY_CYC)
    ) u_nv_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .sw_store_req(sw_store_req),
        .sw_recall_req(sw_recall_req), .vcc_above_sw(vcc_above_sw),
        .vcc_below_rst(vcc_below_rst), .host_wr(host_wr),
        .st_erase(st_erase), .st_prog(st_prog), .rc_clear(rc_clear),
        .rc_copy(rc_copy), .busy(busy), .out_dis(out_dis)
    );

    // Behavioural array model driven by the phase outputs.
    initial begin
        nv[0] = 8'h11; nv[1] = 8'h22; nv[2] = 8'h33; nv[3] = 8'h44;
        for (int i = 0; i < 4; i++) sram[i] = 8'h00;
    end

    always @(posedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (st_erase) nv[i] <= 8'hFF;
            if (st_prog)  nv[i] <= sram[i];
            if (rc_clear) sram[i] <= 8'h00;
            if (rc_copy)  sram[i] <= nv[i];
        end
        if (host_wr && !busy) sram[wr_addr] <= wr_data;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_tally();
        c_gr = 0; c_er = 0; c_pr = 0; c_cl = 0; c_cp = 0; c_bad = 0;
    endtask

    // Each step drops one-cycle request pulses, then tallies the outputs.
    task automatic tally(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sw_store_req  = 1'b0;
            sw_recall_req = 1'b0;
            if (busy && !out_dis) c_gr++;
            if (st_erase) c_er++;
            if (st_prog)  c_pr++;
            if (rc_clear) c_cl++;
            if (rc_copy)  c_cp++;
            if (out_dis && !busy) c_bad++;
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    function automatic int arrays_equal();
        for (int i = 0; i < 4; i++) if (sram[i] != nv[i]) return 0;
        return 1;
    endfunction

    task automatic t_reset_and_powerup();
        chk("R1 busy after reset", busy, 0);
        chk("R1 out_dis after reset", out_dis, 0);
        chk("R1 phases after reset", st_erase | st_prog | rc_clear | rc_copy, 0);
        for (int i = 0; i < 4; i++) snap[i] = nv[i];
        clear_tally();
        @(negedge clk);
        vcc_above_sw = 1'b1;
        tally(20);
        chk("R1 power-up recall clear cycles", c_cl, CLEAR_CYC);
        chk("R8 power-up recall copy cycles", c_cp, PU_COPY_CYC);
        chk("R1 sram loaded from shadow", arrays_equal(), 1);
        chk("R11 out_dis without busy", c_bad, 0);
    endtask

    task automatic t_sw_store_clean();
        clear_tally();
        @(negedge clk);
        sw_store_req = 1'b1;
        tally(20);
        chk("R2 erase cycles", c_er, ERASE_CYC);
        chk("R2 program cycles", c_pr, PROG_CYC);
        chk("R4 store without writes runs", c_er > 0, 1);
        chk("R2 shadow equals sram", arrays_equal(), 1);
    endtask

    task automatic t_sw_recall();
        for (int i = 0; i < 4; i++) snap[i] = nv[i];
        host_write(2'd1, 8'h5A);
        clear_tally();
        @(negedge clk);
        sw_recall_req = 1'b1;
        tally(20);
        chk("R3 clear cycles", c_cl, CLEAR_CYC);
        chk("R3 copy cycles", c_cp, COPY_CYC);
        chk("R3 sram restored", sram[1], snap[1]);
        chk("R3 shadow unchanged", nv[1], snap[1]);
    endtask

    task automatic t_auto_store_dirty();
        host_write(2'd2, 8'hC3);
        clear_tally();
        @(negedge clk);
        vcc_above_sw = 1'b0;
        tally(20);
        chk("R6 completion window cycles", c_gr, GRACE_CYC);
        chk("R6 auto store erase", c_er, ERASE_CYC);
        chk("R6 auto store program", c_pr, PROG_CYC);
        chk("R6 shadow holds write", nv[2], 8'hC3);
        // Software store with low supply must be refused.
        clear_tally();
        @(negedge clk);
        sw_store_req = 1'b1;
        tally(15);
        chk("R5 store rejected at low supply", c_er, 0);
        chk("R7 no repeat store after clean", c_gr, 0);
        // Shallow recovery: no recall.
        clear_tally();
        @(negedge clk);
        vcc_above_sw = 1'b1;
        tally(15);
        chk("R9 no recall after shallow dip", c_cl + c_cp, 0);
    endtask

    task automatic t_auto_store_clean();
        clear_tally();
        @(negedge clk);
        vcc_above_sw = 1'b0;
        tally(15);
        chk("R6 clean supply drop no activity", c_gr + c_er + c_pr, 0);
        @(negedge clk);
        vcc_above_sw = 1'b1;
        tally(2);
    endtask

    task automatic t_write_while_busy();
        clear_tally();
        @(negedge clk);
        sw_store_req = 1'b1;
        tally(2);
        host_wr = 1'b1; wr_addr = 2'd0; wr_data = 8'h99;
        tally(1);
        host_wr = 1'b0;
        tally(15);
        chk("R7 store ran", c_pr, PROG_CYC);
        clear_tally();
        @(negedge clk);
        vcc_above_sw = 1'b0;
        tally(15);
        chk("R7 busy write left array clean", c_gr + c_er, 0);
        @(negedge clk);
        vcc_above_sw = 1'b1;
        tally(2);
    endtask

    task automatic t_deep_dip_priority();
        @(negedge clk);
        vcc_above_sw = 1'b0;
        vcc_below_rst = 1'b1;
        tally(2);
        vcc_below_rst = 1'b0;
        tally(2);
        clear_tally();
        @(negedge clk);
        vcc_above_sw = 1'b1;
        sw_store_req = 1'b1;
        tally(2);
        sw_recall_req = 1'b1;
        tally(20);
        chk("R10 power-up recall beats store", c_er, 0);
        chk("R8 latched recall clear", c_cl, CLEAR_CYC);
        chk("R8 latched recall copy length", c_cp, PU_COPY_CYC);
        chk("R10 recall during busy dropped", c_cl + c_cp, CLEAR_CYC + PU_COPY_CYC);
        chk("R11 out_dis without busy", c_bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_powerup();
        t_sw_store_clean();
        t_sw_recall();
        t_auto_store_dirty();
        t_auto_store_clean();
        t_write_while_busy();
        t_deep_dip_priority();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule